// File: doc/BRIEF.md
# Bit Group Partition Unit

This unit splits a data word into two groups, using a control word of the same width. Each data bit whose control bit is 1 joins the right group. Each data bit whose control bit is 0 joins the left group. In full-partition mode the right group is packed against bit 0 of the result and the left group is packed against the most significant bit. Each group keeps the bit order it had in the source word.

Two one-sided modes are also available. Right extract returns only the packed right group and zeroes every other bit. Left extract returns only the packed left group and zeroes every other bit. Both groups are computed side by side by one shared packing structure, and the full result merges the two. Software can use right extract as a general gather: it collects scattered index bits and right-justifies them.

Operands enter on a valid/ready stream, and so do results. A transfer happens on any rising edge where valid and ready are both high. The result is registered. The input is ready whenever the output register is empty or is being drained on the same edge. So a stalled consumer stalls the producer without losing a word, and with `out_ready` held high one operation completes per cycle.

Top module: `gp_partition`

## Requirements
- R1: In mode 2'b00, the data bit at index i with control 1 lands at result index equal to the number of control ones below i. Right-group bits therefore sit at the low end in source order.
- R2: In mode 2'b00, the data bit at index i with control 0 lands at result index W-1 minus the number of control zeros above i. Left-group bits therefore sit at the high end in source order.
- R3: In mode 2'b01 (right extract), the result holds the packed right group in its low bits, and every bit at or above the right-group count is zero.
- R4: In mode 2'b10 (left extract), the result holds the packed left group in its high bits, and every bit below W minus the left-group count is zero.
- R5: Mode 2'b11 is reserved. An operation accepted with it returns an all-zero result.
- R6: In mode 2'b00, a control word of all ones or of all zeros returns the source word unchanged.
- R7: An operation accepted on a rising edge makes `out_valid` high after that same edge, which is one cycle of latency.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold steady. `in_ready` equals `!out_valid || out_ready`.
- R9: During and directly after reset, `out_valid` is low and `in_ready` is high.
- R10: For W=8, take source bits a..h from MSB to LSB and control 8'b10111010. The left group is b, f, h and the right group is a, c, d, e, g. The result reads b f h a c d e g from MSB down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand bundle is valid |
| in_ready | output | 1 | Unit can take an operand bundle |
| in_src | input | W | Source data word |
| in_ctl | input | W | Per-bit group selector (1 = right group) |
| in_mode | input | 2 | 00 full, 01 right extract, 10 left extract, 11 reserved |
| out_valid | output | 1 | Result register holds a word |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | W | Result word |

## Verification
A fault in the rank chain moves bits to the wrong place. It shows in the very next result as a result that differs from the expected word. When the fault drops or duplicates a bit, the result also has the wrong population count. A fault in the reversal that feeds the left-group packer shows only in modes that use the left group. Such a fault breaks the result at the high end while the low end stays correct, so the bench sorts its expected results by mode. A fault in the output holding register shows during a consumer stall: the word changes, or an extra word appears, one edge after `out_ready` drops.

// File: rtl/gp_pkg.sv
package gp_pkg;
  typedef enum logic [1:0] {
    GP_FULL  = 2'b00,
    GP_RIGHT = 2'b01,
    GP_LEFT  = 2'b10,
    GP_NONE  = 2'b11
  } gp_mode_e;
endpackage

// File: rtl/gp_rank.sv
// Exclusive prefix count: rank[i] = number of set selector bits below index i.
module gp_rank #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]         sel,
  output logic [W-1:0][CW-1:0] rank
);
  assign rank[0] = '0;
  for (genvar i = 1; i < W; i++) begin : g_chain
    assign rank[i] = rank[i-1] + CW'(sel[i-1]);
  end
endmodule

// File: rtl/gp_pack_low.sv
// Gathers the bits flagged by sel toward bit 0, keeping their order.
module gp_pack_low #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0] data,
  input  logic [W-1:0] sel,
  output logic [W-1:0] packed_o
);
  logic [W-1:0][CW-1:0] rank;

  gp_rank #(.W(W)) u_rank (.sel(sel), .rank(rank));

  always_comb begin
    packed_o = '0;
    for (int j = 0; j < W; j++) begin
      for (int i = j; i < W; i++) begin
        if (sel[i] && (rank[i] == CW'(j))) packed_o[j] = packed_o[j] | data[i];
      end
    end
  end
endmodule

// File: rtl/gp_partition.sv
module gp_partition
  import gp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_src,
  input  logic [W-1:0] in_ctl,
  input  logic [1:0]   in_mode,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic [W-1:0] rev_src, rev_zsel, right_w, left_rev, left_w;
  logic [W-1:0] nxt;
  gp_mode_e     mode;

  // The left group is packed by mirroring the word, turning its zeros into
  // selectors, packing toward bit 0, then mirroring back.
  for (genvar k = 0; k < W; k++) begin : g_mirror
    assign rev_src[k]  = in_src[W-1-k];
    assign rev_zsel[k] = ~in_ctl[W-1-k];
    assign left_w[k]   = left_rev[W-1-k];
  end

  gp_pack_low #(.W(W)) u_right (.data(in_src),  .sel(in_ctl),   .packed_o(right_w));
  gp_pack_low #(.W(W)) u_left  (.data(rev_src), .sel(rev_zsel), .packed_o(left_rev));

  assign mode = gp_mode_e'(in_mode);

  always_comb begin
    unique case (mode)
      GP_FULL:  nxt = right_w | left_w;
      GP_RIGHT: nxt = right_w;
      GP_LEFT:  nxt = left_w;
      default:  nxt = '0;
    endcase
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= nxt;
    end
  end
endmodule

// File: rtl/gp_partition_chk.sv
module gp_partition_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_src,
  input logic [W-1:0] in_ctl,
  input logic [1:0]   in_mode,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data
);
  logic take;
  assign take = in_valid && in_ready;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  p_popcount_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_mode == 2'b00 |=> $countones(out_data) == $countones($past(in_src)));

  p_right_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_mode == 2'b01 |=> (out_data >> $countones($past(in_ctl))) == '0);

  p_left_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_mode == 2'b10 |=> (out_data << (W - $countones($past(in_ctl)))) == '0);

  p_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_mode == 2'b11 |=> out_data == '0);
endmodule

bind gp_partition gp_partition_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_src(in_src), .in_ctl(in_ctl), .in_mode(in_mode),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/gp_partition_bench.sv
module gp_partition_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_src = '0;
  logic [W-1:0] in_ctl = '0;
  logic [1:0]   in_mode = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  bit           driving = 1'b1;
  bit           random_ready = 1'b0;

  always #10 clk = ~clk;

  gp_partition #(.W(W)) u_gp_partition (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_ctl(in_ctl), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [W-1:0] model(logic [W-1:0] s, logic [W-1:0] c, logic [1:0] m);
    logic [W-1:0] r = '0, l = '0;
    int ones = 0, zeros = 0;
    for (int i = 0; i < W; i++) if (c[i]) begin r[ones] = s[i]; ones++; end
    for (int i = W - 1; i >= 0; i--) if (!c[i]) begin l[W-1-zeros] = s[i]; zeros++; end
    case (m)
      2'b00: return r | l;
      2'b01: return r;
      2'b10: return l;
      default: return '0;
    endcase
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic send(logic [W-1:0] s, logic [W-1:0] c, logic [1:0] m, string tag);
    bit done = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_src = s; in_ctl = c; in_mode = m;
    while (!done) begin
      #1;
      if (in_ready) begin
        exp_q.push_back(model(s, c, m));
        tag_q.push_back(tag);
        done = 1'b1;
        @(negedge clk);
        checks++;
        if (!out_valid) begin
          errors++;
          $display("FAIL R7 actual out_valid=0 expected=1");
        end
      end else begin
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
  endtask

  function automatic string tag_for(logic [W-1:0] c, logic [1:0] m);
    if (m == 2'b01) return "R3";
    if (m == 2'b10) return "R4";
    if (m == 2'b11) return "R5";
    if (c == '0 || c == '1) return "R6";
    return "R1 R2";
  endfunction

  // Monitor: drives out_ready just after each edge, consumes at negedge.
  initial begin
    logic [W-1:0] held;
    bit           stalled = 1'b0;
    forever begin
      @(posedge clk);
      #2;
      out_ready = random_ready ? ($urandom_range(0, 3) != 0) : 1'b1;
      @(negedge clk);
      if (rst_n && stalled) begin
        check("R8 hold", {out_valid, out_data}, {1'b1, held});
      end
      if (rst_n) begin
        checks++;
        if (in_ready !== (!out_valid || out_ready)) begin
          errors++;
          $display("FAIL R8 actual in_ready=%b expected=%b", in_ready, !out_valid || out_ready);
        end
      end
      stalled = out_valid && !out_ready;
      held = out_data;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          errors++; checks++;
          $display("FAIL R8 actual=extra word expected=none");
        end else begin
          check(tag_q.pop_front(), out_data, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 out_valid", {7'b0, out_valid}, 8'h00);
    check("R9 in_ready", {7'b0, in_ready}, 8'h01);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 out_valid after", {7'b0, out_valid}, 8'h00);

    // R10 worked example: a..h = 0,1,0,0,0,1,0,1 -> b f h a c d e g = 11100000
    send(8'b0100_0101, 8'b1011_1010, 2'b00, "R10");
    send(8'b1011_0010, 8'b1011_1010, 2'b00, "R10");
    send(8'hA5, 8'hFF, 2'b00, "R6");
    send(8'h3C, 8'h00, 2'b00, "R6");
    send(8'b1001_0110, 8'b0101_0101, 2'b00, "R1 R2");
    send(8'hFF, 8'b0000_0001, 2'b01, "R3");
    send(8'hFF, 8'b1000_0000, 2'b10, "R4");
    send(8'hFF, 8'h5A, 2'b11, "R5");
    random_ready = 1'b1;
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] s, c;
      logic [1:0]   m;
      s = W'($urandom);
      c = W'($urandom);
      m = 2'($urandom_range(0, 3));
      if (n % 10 == 0) c = '1;
      if (n % 10 == 1) c = '0;
      if (n % 10 == 2) c = W'(1) << (n % W);
      send(s, c, m, tag_for(c, m));
    end
    random_ready = 1'b0;
    repeat (10) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R7 actual=%0d pending expected=0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule